// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block holds the per-line state of a general-purpose I/O controller behind a plain 32-bit register bus. The lines are grouped eight to a bank. Each bank has two words: a data word and a direction word. A line whose direction bit is set is an input. A line whose direction bit is clear is an output, and it drives the pad with its data bit. Reading a data word returns the synchronised pad level for input lines and the latched output value for output lines. Software changes single lines by reading a word, masking it and writing the whole word back.

Bank words do not form one contiguous run. The base of bank n is (n+1)*8, so bank 0 starts at 0x08. Any base that would land at 0x90 or higher is moved up by 0x10. This keeps the 16-byte window 0x90–0x9F free for the interrupt-control registers: enable, mode, filter enable and filter period. This block decodes that window and forwards accesses to it to a separate interrupt block, whose read data it returns.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every direction bit is 1, every data bit is 0 and pad_oe is all zero. The direction word of a full bank reads 0x000000FF and its data word reads 0 while the pads are low.
- R2: Bank n has its data word at byte address (n+1)*8 and its direction word at (n+1)*8+4, as long as that base is below 0x90. Line 8n+k is bit k of both words.
- R3: A bank whose computed base is 0x90 or above is placed 0x10 higher. Bank 16 is at 0x88/0x8C and bank 17 is at 0xA0/0xA4.
- R4: Direction bit 1 makes a line an input, with its pad_oe bit at 0. Direction bit 0 makes the line an output, with its pad_oe bit at 1 and pad_out equal to the data bit, from the cycle after the write.
- R5: A data word read returns the synchronised pad level in bits whose line is an input and the stored data bit in bits whose line is an output.
- R6: A change on pad_in is not visible in a data read after one rising clock edge. It is visible after the second edge.
- R7: A bank write replaces all 8 line bits of the addressed word at once and leaves every other register unchanged. Bits 31:8 of any bank word read as 0.
- R8: Addresses above the last bank's direction word, and outside 0x90–0x9F, read as 0. Writes to them change no register.
- R9: For addresses 0x90–0x9F, irq_sel is 1 and irq_we follows bus_we. Reads return irq_rdata, and writes change no bank register.
- R10: In a partly filled last bank, bits for lines at or above NUM_LINES read as 0. With 148 lines, bank 18's direction word reads 0x0F after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_sel | output | 1 | Address is in the interrupt window |
| irq_we | output | 1 | Write strobe for the interrupt block |
| irq_addr | output | 4 | Low address bits for the interrupt block |
| irq_wdata | output | 32 | Write data forwarded to the interrupt block |
| irq_rdata | input | 32 | Read data from the interrupt block |
| pad_out | output | NUM_LINES | Output value per line |
| pad_oe | output | NUM_LINES | Output enable per line |
| pad_in | input | NUM_LINES | Asynchronous pad input per line |

## Verification
The address map is probed at the banks on either side of the interrupt window, inside the window, in the partly filled last bank and past the end of the map. Together these separate the base formula, the window skip and the out-of-range decode. A half-input, half-output direction word combined with unlike pad and data patterns (0xA5 against 0x3C) shows which source each bit of a data read comes from. A pad change is sampled after one edge and again after two, to tell the two-flop delay apart from one flop or none. Writes carrying junk in bits 31:8 confirm that whole-word updates touch only the addressed word.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int NUM_LINES = 148,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 irq_sel,
  output logic                 irq_we,
  output logic [3:0]           irq_addr,
  output logic [31:0]          irq_wdata,
  input  logic [31:0]          irq_rdata,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  input  logic [NUM_LINES-1:0] pad_in
);
  localparam int LPB    = 8;
  localparam int NBANKS = (NUM_LINES + LPB - 1) / LPB;
  localparam int PAD_W  = NBANKS * LPB;
  localparam int WA     = ADDR_W - 2;
  localparam int WIN    = 'h90;
  localparam logic [PAD_W-1:0] LINE_MASK = {PAD_W{1'b1}} >> (PAD_W - NUM_LINES);

  function automatic int bank_base(int b);
    int r;
    r = (b + 1) * 8;
    if (r >= WIN) r = r + 16;
    return r;
  endfunction

  logic [PAD_W-1:0] data_q, dir_q, sync1, sync2, rd_line;
  logic [WA-1:0]    word;

  assign word      = bus_addr[ADDR_W-1:2];
  assign irq_sel   = (int'(bus_addr) >= WIN) && (int'(bus_addr) < WIN + 16);
  assign irq_we    = irq_sel & bus_we;
  assign irq_addr  = bus_addr[3:0];
  assign irq_wdata = bus_wdata;

  assign pad_out = data_q[NUM_LINES-1:0];
  assign pad_oe  = ~dir_q[NUM_LINES-1:0];
  assign rd_line = ((dir_q & sync2) | (~dir_q & data_q)) & LINE_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= PAD_W'(pad_in);
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
    end else if (bus_we) begin
      for (int b = 0; b < NBANKS; b++) begin
        if (word == WA'(bank_base(b) >> 2))
          data_q[b*LPB +: LPB] <= bus_wdata[LPB-1:0];
        if (word == WA'((bank_base(b) >> 2) + 1))
          dir_q[b*LPB +: LPB] <= bus_wdata[LPB-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (irq_sel) bus_rdata = irq_rdata;
    for (int b = 0; b < NBANKS; b++) begin
      if (word == WA'(bank_base(b) >> 2))
        bus_rdata = {24'b0, rd_line[b*LPB +: LPB]};
      if (word == WA'((bank_base(b) >> 2) + 1))
        bus_rdata = {24'b0, dir_q[b*LPB +: LPB] & LINE_MASK[b*LPB +: LPB]};
    end
  end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int NUM_LINES = 148,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 irq_sel,
  input logic                 irq_we,
  input logic [31:0]          irq_rdata,
  input logic [NUM_LINES-1:0] pad_out,
  input logic [NUM_LINES-1:0] pad_oe
);
  localparam int NBANKS   = (NUM_LINES + 7) / 8;
  localparam int LAST_RAW = NBANKS * 8;
  localparam int LAST_END = (LAST_RAW >= 'h90 ? LAST_RAW + 16 : LAST_RAW) + 8;

  a_r1_oe_off_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pad_oe == '0);

  a_r2_bank0_data_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && int'(bus_addr) == 'h08) |=> pad_out[7:0] == $past(bus_wdata[7:0]));

  a_r4_bank0_dir_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && int'(bus_addr) == 'h0C) |=> pad_oe[7:0] == ~$past(bus_wdata[7:0]));

  a_r7_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_sel |-> bus_rdata[31:8] == 24'b0);

  a_r8_beyond_map_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_sel && int'(bus_addr) >= LAST_END) |-> bus_rdata == 32'b0);

  a_r9_window_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sel |-> (bus_rdata == irq_rdata && irq_we == bus_we));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_sel(irq_sel),
  .irq_we(irq_we), .irq_rdata(irq_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_gpio_bank_regs.sv
`timescale 1ns/1ps
module tb_gpio_bank_regs;
  localparam int NL = 148;
  localparam int AW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_sel, irq_we;
  logic [3:0]    irq_addr;
  logic [31:0]   irq_wdata;
  logic [31:0]   irq_rdata = 32'h1234_5678;
  logic [NL-1:0] pad_out, pad_oe;
  logic [NL-1:0] pad_in = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    int          sel;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  gpio_bank_regs #(.NUM_LINES(NL), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_sel(irq_sel),
    .irq_we(irq_we), .irq_addr(irq_addr), .irq_wdata(irq_wdata),
    .irq_rdata(irq_rdata), .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  // sel: 0 read data at address, 1 pad_out byte of bank idx, 2 pad_oe byte, 3 irq_sel
  task automatic expect_item(input int sel, input logic [AW-1:0] a, input int idx,
                             input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.sel = sel; it.idx = idx; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        logic [NL-1:0] t;
        it = q.pop_front();
        case (it.sel)
          0: act = bus_rdata;
          1: begin t = pad_out >> (it.idx * 8); act = {24'b0, t[7:0]}; end
          2: begin t = pad_oe >> (it.idx * 8); act = {24'b0, t[7:0]}; end
          default: act = {31'b0, irq_sel};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    expect_item(0, 8'h0C, 0, 32'hFF, "R1 bank0 dir reset");
    expect_item(0, 8'h08, 0, 32'h00, "R1 bank0 data reset");
    expect_item(2, 8'h00, 0, 32'h00, "R1 bank0 oe reset");
    expect_item(0, 8'h8C, 0, 32'hFF, "R1 bank16 dir reset");
    expect_item(0, 8'hAC, 0, 32'h0F, "R10 partial bank18 dir");

    @(negedge clk);
    pad_in[7:0] = 8'hA5;
    expect_item(0, 8'h08, 0, 32'h00, "R6 one edge still old");
    expect_item(0, 8'h08, 0, 32'hA5, "R6 two edges new");

    wr(8'h0C, 32'h0000_000F);
    wr(8'h08, 32'h0000_003C);
    expect_item(2, 8'h00, 0, 32'hF0, "R4 oe from dir");
    expect_item(1, 8'h00, 0, 32'h3C, "R4 pad_out from data");
    expect_item(0, 8'h08, 0, 32'h35, "R5 mixed read");

    wr(8'h08, 32'hABCD_EF5A);
    expect_item(1, 8'h00, 0, 32'h5A, "R7 whole word pad_out");
    expect_item(0, 8'h08, 0, 32'h55, "R7 whole word read");
    expect_item(0, 8'h10, 0, 32'h00, "R7 bank1 data untouched");
    expect_item(0, 8'h14, 0, 32'hFF, "R7 bank1 dir untouched");

    wr(8'h1C, 32'hFFFF_FF00);
    wr(8'h18, 32'h0000_00C3);
    expect_item(1, 8'h00, 2, 32'hC3, "R2 bank2 pad_out");
    expect_item(0, 8'h18, 0, 32'hC3, "R2 bank2 read");
    expect_item(2, 8'h00, 2, 32'hFF, "R2 bank2 oe");

    wr(8'h8C, 32'h0);
    wr(8'h88, 32'h77);
    expect_item(0, 8'h88, 0, 32'h77, "R3 bank16 at 0x88");
    wr(8'hA4, 32'h0);
    wr(8'hA0, 32'h99);
    expect_item(1, 8'h00, 17, 32'h99, "R3 bank17 pad_out");
    expect_item(0, 8'hA0, 0, 32'h99, "R3 bank17 at 0xA0");

    expect_item(0, 8'h94, 0, 32'h1234_5678, "R9 window read");
    expect_item(3, 8'h98, 0, 32'h1, "R9 irq_sel in window");
    expect_item(3, 8'h88, 0, 32'h0, "R9 irq_sel outside");
    wr(8'h90, 32'h0);
    wr(8'h9C, 32'hFF);
    expect_item(0, 8'h88, 0, 32'h77, "R9 bank16 untouched");
    expect_item(0, 8'hA0, 0, 32'h99, "R9 bank17 untouched");

    wr(8'hB0, 32'hFF);
    wr(8'hB4, 32'h0);
    expect_item(0, 8'hB0, 0, 32'h0, "R8 beyond map read");
    expect_item(0, 8'hB4, 0, 32'h0, "R8 beyond map read dir");
    expect_item(0, 8'hAC, 0, 32'h0F, "R8 bank18 dir untouched");
    expect_item(2, 8'h00, 18, 32'h00, "R8 bank18 oe untouched");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule